// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame should be taken into the receive buffer. It compares the frame's four identifier bytes against eight code bytes and eight mask bytes supplied by the host. The code and mask bytes form two banks of four bytes each. The active filter mode sets how those banks are read:

- two wide filters, one per bank;
- four medium filters, two per bank;
- eight narrow filters, four per bank;
- a closed setting that accepts nothing.

A mask bit of 1 makes the matching identifier bit don't-care. A filter hits when every bit that is still compared equals its code bit.

The receive path raises `frame_valid` for one cycle while the identifier bytes are on `id_bytes`. One clock later the block answers with a one-cycle `accept` pulse and the 3-bit index of the lowest-numbered filter that hit. The mode is captured from `mode_req` only while `init_mode` is high. The same input also holds acceptance off.

Top module: `can_id_filter`

## Requirements
- R1: In wide mode (`mode` code 2'b00), filter f (f = 0 or 1) compares all 32 bits of `id_bytes` against code bytes 4f..4f+3. For an extended frame these 32 bits are the 29 identifier bits, SRR, IDE and RTR. Each code byte k lies at bits [8k+7:8k] of `code_bytes`, and identifier byte j lies at bits [8j+7:8j] of `id_bytes`.
- R2: In medium mode (2'b01), filter f (f = 0..3) compares `id_bytes[15:0]` against code bytes 2f and 2f+1. This covers the 11 identifier bits and RTR of a standard frame, or the top 14 identifier bits plus SRR and IDE of an extended frame.
- R3: In narrow mode (2'b10), filter f (f = 0..7) compares `id_bytes[7:0]` against code byte f.
- R4: A mask bit of 1 excludes its bit from comparison. A frame is standard when IDE (`id_bytes[11]`) is 0. For a standard frame, bits [10:8] and [31:16] of `id_bytes` are never compared.
- R5: In closed mode (2'b11), `accept` never rises.
- R6: The mode resets to closed. It is loaded from `mode_req` only at clock edges where `init_mode` is high; changes to `mode_req` at other times have no effect.
- R7: `accept` is low during reset and in the cycle after any clock edge at which `init_mode` was high.
- R8: `accept` and `hit_idx` are registered one clock after the `frame_valid` strobe and last one cycle. `hit_idx` names the lowest-numbered filter that hit, and it is 0 whenever `accept` is low.
- R9: `accept` rises only in the cycle after a clock edge at which `frame_valid` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Initialisation window: the mode may be loaded and acceptance is held off |
| mode_req | input | 2 | Requested filter mode, captured while `init_mode` is high |
| code_bytes | input | 64 | Eight acceptance code bytes; byte k at [8k+7:8k] |
| mask_bytes | input | 64 | Eight mask bytes; a bit of 1 means don't-care |
| id_bytes | input | 32 | Received identifier bytes; byte j at [8j+7:8j] |
| frame_valid | input | 1 | One-cycle strobe marking a received identifier |
| accept | output | 1 | One-cycle pulse: the frame passed a filter |
| hit_idx | output | 3 | Index of the lowest-numbered filter that hit |

## Verification
The assertions assume the following about the inputs:
- `code_bytes`, `mask_bytes` and `id_bytes` are stable across the clock edge where the strobe is sampled.
- `frame_valid` and `init_mode` are driven only between edges.

The stimulus changes every input at the falling clock edge. It steers the mode only through pulses on `init_mode`. Some strobes coincide with `init_mode`, so the suppression path is exercised without breaking these assumptions.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int BANKS      = 2;
    localparam int BANK_BYTES = 4;
    localparam int CODE_BYTES = BANKS * BANK_BYTES;
    localparam int CODE_W     = CODE_BYTES * 8;
    localparam int ID_W       = BANK_BYTES * 8;
    localparam int MAX_FILT   = CODE_BYTES;
    localparam int IDX_W      = $clog2(MAX_FILT);
    localparam int IDE_POS    = 11;
    // bits never compared for a standard frame: byte1[2:0] and bytes 2..3
    localparam logic [ID_W-1:0] STD_DC = 32'hFFFF_0700;

    typedef enum logic [1:0] {
        FMODE_WIDE   = 2'b00,
        FMODE_MID    = 2'b01,
        FMODE_NARROW = 2'b10,
        FMODE_CLOSED = 2'b11
    } fmode_e;

    typedef struct packed {
        fmode_e           mode;
        logic             accept;
        logic [IDX_W-1:0] idx;
    } filt_state_t;
endpackage

// File: rtl/can_filt_field_cmp.sv
module can_filt_field_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] code,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] forced_dc,
    input  logic [W-1:0] data,
    output logic         match
);
    logic [W-1:0] bit_ok;

    always_comb begin
        bit_ok = ~(code ^ data) | mask | forced_dc;
        match  = &bit_ok;
    end
endmodule

// File: rtl/can_filt_slicer.sv
module can_filt_slicer
    import can_filt_pkg::*;
#(
    parameter int FW = 32
) (
    input  logic [CODE_W-1:0] code_bytes,
    input  logic [CODE_W-1:0] mask_bytes,
    input  logic [ID_W-1:0]   id_bytes,
    input  logic              std_frame,
    output logic [CODE_W/FW-1:0] hits
);
    localparam int NF = CODE_W / FW;

    logic [FW-1:0] dc_vec;

    always_comb begin
        dc_vec = std_frame ? STD_DC[FW-1:0] : '0;
    end

    for (genvar f = 0; f < NF; f++) begin : g_filt
        can_filt_field_cmp #(.W(FW)) u_cmp (
            .code      (code_bytes[f*FW +: FW]),
            .mask      (mask_bytes[f*FW +: FW]),
            .forced_dc (dc_vec),
            .data      (id_bytes[FW-1:0]),
            .match     (hits[f])
        );
    end
endmodule

// File: rtl/can_filt_prio_enc.sv
module can_filt_prio_enc #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic          any_hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        any_hit = 1'b0;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                idx     = IW'(i);
            end
        end
    end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_mode,
    input  logic [1:0]        mode_req,
    input  logic [CODE_W-1:0] code_bytes,
    input  logic [CODE_W-1:0] mask_bytes,
    input  logic [ID_W-1:0]   id_bytes,
    input  logic              frame_valid,
    output logic              accept,
    output logic [IDX_W-1:0]  hit_idx
);
    localparam int NF_WIDE   = CODE_W / 32;
    localparam int NF_MID    = CODE_W / 16;
    localparam int NF_NARROW = CODE_W / 8;

    filt_state_t st_d, st_q;

    logic                 std_frame;
    logic [NF_WIDE-1:0]   hits_wide;
    logic [NF_MID-1:0]    hits_mid;
    logic [NF_NARROW-1:0] hits_narrow;
    logic [MAX_FILT-1:0]  hit_vec;
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;

    assign std_frame = ~id_bytes[IDE_POS];

    can_filt_slicer #(.FW(32)) u_wide (
        .code_bytes (code_bytes), .mask_bytes (mask_bytes),
        .id_bytes   (id_bytes),   .std_frame  (std_frame),
        .hits       (hits_wide)
    );
    can_filt_slicer #(.FW(16)) u_mid (
        .code_bytes (code_bytes), .mask_bytes (mask_bytes),
        .id_bytes   (id_bytes),   .std_frame  (std_frame),
        .hits       (hits_mid)
    );
    can_filt_slicer #(.FW(8)) u_narrow (
        .code_bytes (code_bytes), .mask_bytes (mask_bytes),
        .id_bytes   (id_bytes),   .std_frame  (std_frame),
        .hits       (hits_narrow)
    );

    always_comb begin
        case (st_q.mode)
            FMODE_WIDE:   hit_vec = {{(MAX_FILT-NF_WIDE){1'b0}}, hits_wide};
            FMODE_MID:    hit_vec = {{(MAX_FILT-NF_MID){1'b0}}, hits_mid};
            FMODE_NARROW: hit_vec = hits_narrow;
            default:      hit_vec = '0;
        endcase
    end

    can_filt_prio_enc #(.N(MAX_FILT), .IW(IDX_W)) u_prio (
        .hits    (hit_vec),
        .any_hit (any_hit),
        .idx     (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (init_mode) begin
            st_d.mode = fmode_e'(mode_req);
        end
        st_d.accept = frame_valid && !init_mode && any_hit;
        st_d.idx    = st_d.accept ? win_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: FMODE_CLOSED, accept: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept  = st_q.accept;
    assign hit_idx = st_q.idx;

    AST_CLOSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == FMODE_CLOSED) |=> !accept); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |=> $stable(st_q.mode)); // R6
    AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        init_mode |=> !accept); // R7
    AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> (hit_idx == '0)); // R8
    AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !accept); // R9
    AST_WIN_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !init_mode) |-> (any_hit == (hit_vec != '0))); // R8
endmodule

// File: tb/sim_can_id_filter.sv
module sim_can_id_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_mode = 1'b0;
    logic [1:0]  mode_req = 2'b11;
    logic [63:0] code_bytes = '0;
    logic [63:0] mask_bytes = '0;
    logic [31:0] id_bytes = '0;
    logic        frame_valid = 1'b0;
    logic        accept;
    logic [2:0]  hit_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_tag = "R7";

    // bench-side model state
    int mode_m = 3;
    bit exp_acc = 0;
    int exp_idx = 0;

    always #2 clk = ~clk;

    can_id_filter u0 (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .mode_req(mode_req),
        .code_bytes(code_bytes), .mask_bytes(mask_bytes), .id_bytes(id_bytes),
        .frame_valid(frame_valid), .accept(accept), .hit_idx(hit_idx)
    );

    function automatic int ref_hit(int md, logic [31:0] id, logic [63:0] cd, logic [63:0] mk);
        int nf;
        int w;
        bit ide;
        ide = id[11];
        case (md)
            0: begin nf = 2; w = 32; end
            1: begin nf = 4; w = 16; end
            2: begin nf = 8; w = 8; end
            default: return -1;
        endcase
        for (int f = 0; f < nf; f++) begin
            bit ok = 1;
            for (int b = 0; b < w; b++) begin
                int pos = f * w + b;
                bit dc = mk[pos];
                if (!ide && (b >= 16 || (b >= 8 && b <= 10))) dc = 1;
                if (!dc && cd[pos] != id[b]) ok = 0;
            end
            if (ok) return f;
        end
        return -1;
    endfunction

    function automatic logic [31:0] ext_frame(logic [28:0] id, bit srr, bit rtr);
        return {id[6:0], rtr, id[14:7], id[20:18], srr, 1'b1, id[17:15], id[28:21]};
    endfunction

    function automatic logic [31:0] std_frame(logic [10:0] id, bit rtr, logic [2:0] junk, logic [15:0] tail);
        return {tail, id[2:0], rtr, 1'b0, junk, id[10:3]};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // one clock: model at the rising edge, compare at the falling edge
    task automatic cycle();
        int h;
        @(posedge clk);
        if (!rst_n) begin
            exp_acc = 0; exp_idx = 0; mode_m = 3;
        end else begin
            h = ref_hit(mode_m, id_bytes, code_bytes, mask_bytes);
            exp_acc = frame_valid && !init_mode && (h >= 0);
            exp_idx = exp_acc ? h : 0;
            if (init_mode) mode_m = int'(mode_req);
        end
        @(negedge clk);
        check({cur_tag, " accept"}, int'(accept), int'(exp_acc));
        check({cur_tag, " hit_idx"}, int'(hit_idx), exp_idx);
    endtask

    task automatic set_mode(int m);
        init_mode = 1; mode_req = 2'(m);
        cycle();
        init_mode = 0;
        cycle();
    endtask

    task automatic frame(logic [31:0] id, int e_acc, int e_idx, string tag);
        cur_tag = tag;
        id_bytes = id; frame_valid = 1;
        cycle();
        frame_valid = 0;
        check({tag, " literal accept"}, int'(accept), e_acc);
        check({tag, " literal idx"}, int'(hit_idx), e_idx);
        cycle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [28:0] ida, idb;
        logic [31:0] fb;
        // R7: reset state
        for (int i = 0; i < 3; i++) cycle();
        check("R7 reset accept", int'(accept), 0);
        check("R7 reset idx", int'(hit_idx), 0);
        rst_n = 1;
        cycle();

        // R5/R6: reset mode is closed
        mask_bytes = '1;
        frame(32'h1234_5678, 0, 0, "R5");

        // R1: wide mode, extended frames
        set_mode(0);
        ida = 29'h0ABC_1234; idb = 29'h1555_00FF;
        mask_bytes = '0;
        code_bytes = {ext_frame(idb, 1, 0), ext_frame(ida, 1, 0)};
        frame(ext_frame(idb, 1, 0), 1, 1, "R1");
        frame(ext_frame(ida, 1, 1), 0, 0, "R1");
        // R4: masking the RTR bit of bank 0 lets it through
        mask_bytes[24] = 1'b1;
        frame(ext_frame(ida, 1, 1), 1, 0, "R4");
        // R4: standard frame ignores byte1[2:0] and bytes 2..3
        mask_bytes = '0;
        code_bytes[31:0] = std_frame(11'h5A3, 0, 3'b000, 16'hAAAA);
        frame(std_frame(11'h5A3, 0, 3'b111, 16'h5555), 1, 0, "R4");
        frame(std_frame(11'h5A2, 0, 3'b111, 16'h5555), 0, 0, "R4");

        // R2: medium mode
        set_mode(1);
        code_bytes = '0;
        code_bytes[47:32] = std_frame(11'h3C1, 1, 3'b000, 16'h0)[15:0];
        fb = ext_frame(29'h1F0F_0F0F, 1, 0);
        code_bytes[63:48] = fb[15:0];
        frame(std_frame(11'h3C1, 1, 3'b101, 16'h1234), 1, 2, "R2");
        frame({16'hBEEF, fb[15:0]}, 1, 3, "R2");
        frame(std_frame(11'h3C1, 0, 3'b000, 16'h0), 0, 0, "R2");

        // R3/R8: narrow mode, lowest index wins
        set_mode(2);
        code_bytes = 64'h3C11_3C22_3344_5566;
        frame(32'hFFFF_FF3C, 1, 5, "R8");
        frame(32'h0000_0066, 1, 0, "R3");
        frame(32'h0000_0022, 1, 4, "R3");
        frame(32'h0000_0099, 0, 0, "R3");

        // R6: mode request outside init is ignored
        mode_req = 2'b11;
        cycle();
        frame(32'h0000_003C, 1, 5, "R6");

        // R7: strobe during init is suppressed
        cur_tag = "R7";
        init_mode = 1; mode_req = 2'b10; id_bytes = 32'h3C; frame_valid = 1;
        cycle();
        init_mode = 0; frame_valid = 0;
        check("R7 init suppress", int'(accept), 0);
        cycle();

        // R5: closed mode
        set_mode(3);
        mask_bytes = '1;
        frame(32'h0, 0, 0, "R5");

        // R9: no strobe, matching data
        set_mode(2);
        cur_tag = "R9";
        id_bytes = 32'h3C;
        for (int i = 0; i < 4; i++) cycle();

        // random phase, checked against the model every cycle
        cur_tag = "R8";
        for (int i = 0; i < 4000; i++) begin
            init_mode = ($urandom_range(0, 29) == 0);
            mode_req = 2'($urandom);
            code_bytes = {$urandom, $urandom};
            mask_bytes = {$urandom | $urandom, $urandom | $urandom};
            case ($urandom_range(0, 2))
                0: id_bytes = code_bytes[31:0] ^ (32'h1 << $urandom_range(0, 31));
                1: id_bytes = code_bytes[63:32];
                default: id_bytes = $urandom;
            endcase
            frame_valid = $urandom_range(0, 1);
            cycle();
        end
        init_mode = 0; frame_valid = 0;
        cycle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule